// File: doc/BRIEF.md
# Serial-Bus Register Slave with Hang Timer

This block is a two-wire serial-bus slave that answers one fixed 7-bit device address (0x6A) and gives a bus master read and write access to a byte-wide register file of seven entries. The master opens a transfer with a START, sends the address byte, and on a write follows it with a register pointer byte and any number of data bytes. Reads use the current pointer, usually set by a pointer-only write followed by a repeated START. SCL and SDA arrive raw, are synchronised into the system clock, and the slave drives SDA only through an open-drain enable. The stored registers are visible in parallel on `reg_q`. Register 0x00 has a read-only upper nibble that comes from live status inputs.

A hang timer starts on every START or repeated START and stops on a STOP. If a transfer runs longer than `TMO_CYC` system clocks, the engine drops back to idle and ignores the bus until the next START.

The engine is one state machine. Its states are IDLE, ADDR (shift in the address byte), AACK (acknowledge the address), PTR (shift in the pointer), PACK (acknowledge the pointer), WDAT (shift in a data byte), WACK (acknowledge and write), RDAT (shift out a data byte) and MACK (sample the master's acknowledge). The transitions are:
- START goes from any state to ADDR.
- STOP or a timer expiry goes from any state to IDLE.
- ADDR goes to AACK on a match, or to IDLE on a mismatch.
- AACK goes to RDAT or PTR, chosen by the direction bit.
- PTR goes to PACK, and PACK goes to WDAT.
- WDAT goes to WACK, and WACK goes back to WDAT.
- RDAT goes to MACK.
- MACK goes back to RDAT on an ACK, or to IDLE on a NACK.

Every transition other than START, STOP and the timer expiry happens on a falling SCL edge.

Top module: `serreg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 0x6A is acknowledged. Any other address is not acknowledged, and the slave leaves SDA alone until the next START.
- R2: On every acknowledge the slave gives, it holds SDA low for the whole high period of the ninth SCL clock.
- R3: In a write, the byte after the address is the register pointer and the following bytes are data. Each data byte is received MSB first, acknowledged, and stored in the register the pointer selects.
- R4: The register pointer advances by one after every data byte, in writes and in reads.
- R5: In a read, the slave sends the selected register MSB first. A NACK from the master ends the read, and SDA is released for that ninth clock and after it.
- R6: A read from a pointer of 7 or above returns 0xFF. A write to such a pointer is acknowledged and changes no register.
- R7: After reset the registers at 0x01 to 0x06 read 0x00, 0x8F, 0xF8, 0x00, 0x00 and 0xE0. Register 0x00 reads with its low nibble at 0.
- R8: Bits 7:4 of register 0x00 always show `live_stat`. Writes affect only bits 3:0 of that register.
- R9: A repeated START restarts address decoding without a STOP, so a pointer write followed by a read works.
- R10: A transfer that lasts more than `TMO_CYC` clocks after its last START or repeated START resets the engine. Later bytes get no acknowledge and write nothing until a new START arrives.
- R11: A STOP returns the engine to idle. Bytes clocked without a preceding START are ignored.
- R12: While reset is asserted, SDA is not driven and `reg_q` holds the reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock from the bus |
| sda_in | input | 1 | Raw serial data as seen on the bus |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| live_stat | input | 4 | Live status bits shown in register 0x00 bits 7:4 |
| reg_q | output | 56 | Register contents, register n at bits 8n+7:8n |

## Verification
The bench builds the block with `TMO_CYC` = 3000, well below the default. With that value a normal four-byte transfer finishes inside the window at a 40-clock bit time, while a stall of 3500 clocks in the middle of a write trips the timer within a short run. The device address stays at its default of 0x6A, so matching and mismatching address bytes are both exercised against the fixed value.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int NREG = 7;
    localparam logic [6:0] DEV_ADDR_DEF = 7'h6A;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK,
        S_WDAT, S_WACK, S_RDAT, S_MACK
    } st_e;

    function automatic logic [7:0] reset_val(input int idx);
        case (idx)
            2:       return 8'h8F;
            3:       return 8'hF8;
            6:       return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/serreg_regfile.sv
module serreg_regfile
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    input  logic [3:0]        live_stat,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] view
);
    logic [NREG*8-1:0] store;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store[g*8 +: 8] <= reset_val(g);
            else if (wr_en && wr_addr == 8'(g))
                store[g*8 +: 8] <= wr_data;
        end
    end

    always_comb begin
        view       = store;
        view[7:4]  = live_stat;
        rd_data    = 8'hFF;
        if (rd_addr < 8'(NREG))
            rd_data = view[rd_addr*8 +: 8];
    end

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 8'(NREG)) |=> $stable(store)); // R6
endmodule

// File: rtl/serreg_fsm.sv
module serreg_fsm
    import serreg_pkg::*;
#(
    parameter int         TMO_CYC  = 25000,
    parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam int TW = $clog2(TMO_CYC + 1);

    st_e           state, nxt;
    logic [3:0]    cnt;
    logic [7:0]    sh, tx;
    logic          rw, nack_r;
    logic          tmo_act, tmo_fire;
    logic [TW-1:0] tmo_cnt;

    assign tmo_fire = tmo_act && (tmo_cnt == TW'(TMO_CYC - 1));

    always_comb begin
        nxt = state;
        if (start_det)
            nxt = S_ADDR;
        else if (stop_det || tmo_fire)
            nxt = S_IDLE;
        else if (scl_fall) begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_ADDR: if (cnt == 4'd8) nxt = (sh[7:1] == DEV_ADDR) ? S_AACK : S_IDLE;
                S_AACK: nxt = rw ? S_RDAT : S_PTR;
                S_PTR:  if (cnt == 4'd8) nxt = S_PACK;
                S_PACK: nxt = S_WDAT;
                S_WDAT: if (cnt == 4'd8) nxt = S_WACK;
                S_WACK: nxt = S_WDAT;
                S_RDAT: if (cnt == 4'd7) nxt = S_MACK;
                S_MACK: nxt = nack_r ? S_IDLE : S_RDAT;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '1;
            rw      <= 1'b0;
            nack_r  <= 1'b1;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            tmo_act <= 1'b0;
            tmo_cnt <= '0;
        end else begin
            state <= nxt;
            wr_en <= 1'b0;
            if (start_det) begin
                tmo_act <= 1'b1;
                tmo_cnt <= '0;
            end else if (stop_det || tmo_fire) begin
                tmo_act <= 1'b0;
            end else if (tmo_act) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end

            if (start_det) begin
                cnt <= '0;
            end else if (!tmo_fire && !stop_det) begin
                if (scl_rise && (state == S_ADDR || state == S_PTR || state == S_WDAT)) begin
                    sh  <= {sh[6:0], sda_s};
                    cnt <= cnt + 1'b1;
                end else if (scl_rise && state == S_MACK) begin
                    nack_r <= sda_s;
                end else if (scl_fall) begin
                    case (state)
                        S_ADDR: if (cnt == 4'd8) begin rw <= sh[0]; cnt <= '0; end
                        S_AACK: if (rw) begin tx <= rd_data; cnt <= '0; end
                        S_PTR:  if (cnt == 4'd8) begin ptr <= sh; cnt <= '0; end
                        S_WDAT: if (cnt == 4'd8) begin
                                    wr_en   <= 1'b1;
                                    wr_data <= sh;
                                    cnt     <= '0;
                                end
                        S_WACK: ptr <= ptr + 1'b1;
                        S_RDAT: if (cnt == 4'd7) begin
                                    ptr <= ptr + 1'b1;
                                    cnt <= '0;
                                end else begin
                                    tx  <= {tx[6:0], 1'b1};
                                    cnt <= cnt + 1'b1;
                                end
                        S_MACK: if (!nack_r) tx <= rd_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            S_AACK, S_PACK, S_WACK: sda_oe = 1'b1;
            S_RDAT:                 sda_oe = ~tx[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != DEV_ADDR && !tmo_fire)
        |=> state == S_IDLE); // R1
    AST_OE_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det) && !$past(tmo_fire))
        |-> $stable(sda_oe)); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WACK && scl_fall && !start_det && !tmo_fire)
        |=> ptr == $past(ptr) + 8'd1); // R4
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_fire && !start_det) |=> state == S_IDLE); // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !tmo_act)); // R11
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
    import serreg_pkg::*;
#(
    parameter int         TMO_CYC  = 25000,
    parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [3:0]        live_stat,
    output logic [NREG*8-1:0] reg_q
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, wr_data, rd_data;
    logic       wr_en;

    serreg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    serreg_fsm #(.TMO_CYC(TMO_CYC), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    serreg_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .live_stat(live_stat), .rd_data(rd_data), .view(reg_q)
    );
endmodule

// File: tb/sim_serreg_slave.sv
module sim_serreg_slave;
    localparam int CLK_P = 10;
    localparam int TMO   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0]  live = 4'hA;
    logic        sda_oe;
    logic [55:0] reg_q;
    wire         sda_bus = sda_m & ~sda_oe;

    int tests = 0, fails = 0, mon_err = 0;
    logic done = 1'b0, mon_on = 1'b0;
    logic [7:0] model [7];

    always #(CLK_P/2) clk = ~clk;

    serreg_slave #(.TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .live_stat(live), .reg_q(reg_q)
    );

    function automatic logic [7:0] exp_reg(input int i);
        return (i == 0) ? {live, model[0][3:0]} : model[i];
    endfunction

    // per-clock comparison of the register view against the behavioural model
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < 7; i++)
                if (reg_q[i*8 +: 8] !== exp_reg(i)) begin
                    mon_err++;
                    if (mon_err < 4)
                        $display("monitor mismatch reg %0d: %h vs %h", i, reg_q[i*8 +: 8], exp_reg(i));
                end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cyc(5);  sda_m = 1'b1;
        cyc(15); scl_m = 1'b1;
        cyc(20); sda_m = 1'b0;
        cyc(20); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(5);  sda_m = 1'b0;
        cyc(15); scl_m = 1'b1;
        cyc(20); sda_m = 1'b1;
        cyc(20);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        cyc(5);  sda_m = b;
        cyc(15); scl_m = 1'b1;
        cyc(10); seen = sda_bus;
        cyc(10); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2, d;
        for (int i = 7; i >= 0; i--) bit_io(b[i], d);
        cyc(5);  sda_m = 1'b1;
        cyc(15); scl_m = 1'b1;
        cyc(4);  s1 = sda_bus;
        cyc(14); s2 = sda_bus;
        cyc(2);  scl_m = 1'b0;
        acked = !s1 && !s2;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b, output logic ninth);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            b = {b[6:0], s};
        end
        bit_io(nack, ninth);
    endtask

    initial begin
        logic a;
        logic [7:0] rb;
        logic nb;
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        model[2] = 8'h8F; model[3] = 8'hF8; model[6] = 8'hE0;

        cyc(3);
        chk("R12 sda not driven in reset", {7'd0, sda_oe}, 8'h00);
        for (int i = 0; i < 7; i++) chk("R12 reset value during reset", reg_q[i*8 +: 8], exp_reg(i));
        cyc(2); rst_n = 1'b1; cyc(5);
        mon_on = 1'b1;
        for (int i = 0; i < 7; i++) chk("R7 reset map", reg_q[i*8 +: 8], exp_reg(i));

        // R1 R3 R4: write two bytes from pointer 1
        mon_on = 1'b0;
        bus_start();
        send_byte(8'hD4, a); chk("R1 address ack", {7'd0, a}, 8'h01);
        send_byte(8'h01, a); chk("R2 pointer ack held", {7'd0, a}, 8'h01);
        send_byte(8'hA5, a); chk("R3 data ack", {7'd0, a}, 8'h01);
        send_byte(8'h3C, a); chk("R4 second data ack", {7'd0, a}, 8'h01);
        bus_stop();
        model[1] = 8'hA5; model[2] = 8'h3C;
        chk("R3 reg1 written", reg_q[15:8], 8'hA5);
        chk("R4 reg2 written via increment", reg_q[23:16], 8'h3C);
        mon_on = 1'b1;

        // R1: foreign address
        bus_start();
        send_byte(8'hAA, a); chk("R1 foreign address no ack", {7'd0, a}, 8'h00);
        send_byte(8'h02, a); chk("R1 ignored after mismatch", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R1 reg2 untouched", reg_q[23:16], 8'h3C);

        // R8: write register 0
        mon_on = 1'b0;
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a); send_byte(8'hFF, a);
        bus_stop();
        model[0] = 8'hFF;
        chk("R8 reg0 upper nibble live", reg_q[7:0], 8'hAF);
        mon_on = 1'b1;

        // R9 R5 R4: pointer write, repeated start, read three
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h01, a);
        bus_start();
        send_byte(8'hD5, a); chk("R9 read address ack after Sr", {7'd0, a}, 8'h01);
        recv_byte(1'b0, rb, nb); chk("R5 read reg1", rb, 8'hA5);
        recv_byte(1'b0, rb, nb); chk("R4 read reg2", rb, 8'h3C);
        recv_byte(1'b1, rb, nb); chk("R4 read reg3", rb, 8'hF8);
        chk("R5 released on nack", {7'd0, nb}, 8'h01);
        bus_stop();
        chk("R5 sda idle after stop", {7'd0, sda_bus}, 8'h01);

        // R6: read across end of map
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h06, a);
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(1'b0, rb, nb); chk("R6 read reg6", rb, 8'hE0);
        recv_byte(1'b1, rb, nb); chk("R6 unmapped reads FF", rb, 8'hFF);
        bus_stop();

        // R6: write to unmapped pointer
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h07, a);
        send_byte(8'h12, a); chk("R6 unmapped write acked", {7'd0, a}, 8'h01);
        bus_stop();
        for (int i = 0; i < 7; i++) chk("R6 no register changed", reg_q[i*8 +: 8], exp_reg(i));

        // R10: stall beyond timeout
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h04, a);
        cyc(3500);
        send_byte(8'h77, a); chk("R10 no ack after timeout", {7'd0, a}, 8'h00);
        chk("R10 reg4 unchanged", reg_q[39:32], 8'h00);
        bus_stop();
        mon_on = 1'b0;
        bus_start();
        send_byte(8'hD4, a); chk("R10 engine works after new start", {7'd0, a}, 8'h01);
        send_byte(8'h04, a); send_byte(8'h99, a);
        bus_stop();
        model[4] = 8'h99;
        chk("R10 reg4 written after recovery", reg_q[39:32], 8'h99);
        mon_on = 1'b1;

        // R8: live status change read back
        live = 4'h9;
        cyc(4);
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(1'b1, rb, nb); chk("R8 reg0 read shows live bits", rb, 8'h9F);
        bus_stop();

        // R11: bytes without START ignored
        send_byte(8'hD4, a); chk("R11 no ack without start", {7'd0, a}, 8'h00);
        send_byte(8'h05, a); send_byte(8'h55, a);
        chk("R11 reg5 untouched", reg_q[47:40], 8'h00);
        bus_stop();

        tests++;
        if (mon_err != 0) begin
            fails++;
            $display("FAIL R3 per-clock monitor mismatches actual=%0d expected=0", mon_err);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule